// File: doc/BRIEF.md
# Wrapped Burst Address Generator

This block generates the byte addresses for one flash read burst, as a cache-line fill needs them. A start request brings in a target address, a burst kind and a window-size code. The block then presents one address per data beat on a valid/ready handshake. In wrapped mode the target byte comes first. The following addresses climb to the top of an aligned window, fold back to its bottom, and stop once every byte of the window has been issued.

In linear mode the address simply counts upward, one per accepted beat, until the requester raises a stop input. Serial bus signalling, the data path and the cache lie outside the block. A cache controller places it between its miss logic and the flash command sequencer.

The block takes new work only when it is idle. It samples the kind and the window size at acceptance and holds them for the whole burst.

Top module: `wrap_burst_agen`

## Requirements
- R1: While reset is held, and afterwards until a start is accepted, `idle_o` is 1 and both `addr_valid_o` and `last_o` are 0.
- R2: A start request is taken only in a cycle where `idle_o` is 1. A `start_i` pulse during a burst leaves that burst's address sequence unchanged.
- R3: In the cycle after a start is accepted, `addr_valid_o` is 1 and `addr_o` equals the accepted `start_addr_i`, in both burst kinds.
- R4: `addr_o` moves on only after a clock edge where `addr_valid_o` and `addr_ready_i` are both 1. Otherwise it holds its value while valid stays high.
- R5: In linear mode each accepted beat makes the next address the previous one plus 1, modulo 2^24, so 0xFFFFFF is followed by 0x000000.
- R6: A linear burst ends on a clock edge where `stop_i` is 1. `addr_valid_o` is 0 and `idle_o` is 1 from the following cycle. `last_o` never goes high in linear mode.
- R7: In wrapped mode the window is L bytes long, with `len_code_i` 0→8, 1→16, 2→32 and 3→64. Each beat increments only the low log2(L) address bits, modulo L, and the upper bits do not change.
- R8: A wrapped burst issues exactly L addresses, each byte of the window once. `last_o` is 1 on the L-th address only. After that beat is accepted, valid drops and the block is idle in the next cycle.
- R9: `stop_i` has no effect during a wrapped burst.
- R10: `wrap_mode_i` = 1 selects wrapped mode and 0 selects linear mode. Mode and length code are sampled only at acceptance, so changes to them during a burst are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new burst |
| start_addr_i | input | 24 | Target byte address of the burst |
| wrap_mode_i | input | 1 | 1 wrapped, 0 linear |
| len_code_i | input | 2 | Window size code (8/16/32/64 bytes) |
| stop_i | input | 1 | Ends a linear burst |
| idle_o | output | 1 | Ready to take a start request |
| addr_o | output | 24 | Current beat address |
| addr_valid_o | output | 1 | `addr_o` holds a beat address |
| addr_ready_i | input | 1 | Consumer takes the current address |
| last_o | output | 1 | Final address of a wrapped burst |

## Verification
The bench builds the block with its defaults: a 24-bit address, a 2-bit length code and a smallest window of 8 bytes. These values put the fold-over from 0xFFFFFF to zero, the topmost 64-byte window and all four window sizes within a few hundred cycles. Each table vector combines a start position inside its window (base, middle or top byte) with a gapped ready pattern. During every burst the bench also flips the mode and length inputs and pulses start and stop, so the sampling and ignore rules are exercised on every run.

// File: rtl/wba_pkg.sv
package wba_pkg;

  typedef enum logic {
    BK_LINEAR = 1'b0,
    BK_WRAP   = 1'b1
  } burst_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  // log2 of the window length for a given size code
  function automatic int win_log2(input int code, input int min_log2);
    return min_log2 + code;
  endfunction

endpackage

// File: rtl/wba_req_ctrl.sv
module wba_req_ctrl
  import wba_pkg::*;
#(
  parameter int LEN_CODE_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  wrap_mode_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  stop_i,
  input  logic                  fire_i,
  input  logic                  last_i,
  output logic                  accept_o,
  output logic                  busy_o,
  output burst_kind_e           kind_o,
  output logic [LEN_CODE_W-1:0] code_o
);

  run_state_e            state_q;
  burst_kind_e           kind_q;
  logic [LEN_CODE_W-1:0] code_q;
  logic                  wrap_done;
  logic                  lin_stop;
  logic                  end_burst;

  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign wrap_done = (kind_q == BK_WRAP) && fire_i && last_i;
  assign lin_stop  = (kind_q == BK_LINEAR) && stop_i;
  assign end_burst = (state_q == ST_RUN) && (wrap_done || lin_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= BK_LINEAR;
      code_q  <= '0;
    end else if (accept_o) begin
      state_q <= ST_RUN;
      kind_q  <= burst_kind_e'(wrap_mode_i);
      code_q  <= len_code_i;
    end else if (end_burst) begin
      state_q <= ST_IDLE;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign kind_o = kind_q;
  assign code_o = code_q;

  AST_BUSY_HOLDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n) busy_o |=> (!busy_o || ($stable(kind_o) && $stable(code_o)))); // R10
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && start_i && !end_burst) |=> (busy_o && $stable(kind_o))); // R2
  AST_STOP_ENDS_LINEAR: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && kind_o == BK_LINEAR && stop_i) |=> !busy_o); // R6
  AST_WRAP_IGNORES_STOP: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && kind_o == BK_WRAP && stop_i && !(fire_i && last_i)) |=> busy_o); // R9

endmodule

// File: rtl/wba_beat_cnt.sv
module wba_beat_cnt
  import wba_pkg::*;
#(
  parameter int LEN_CODE_W   = 2,
  parameter int MIN_LEN_LOG2 = 3,
  parameter int CNT_W        = MIN_LEN_LOG2 + (1 << LEN_CODE_W) - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept_i,
  input  logic                  fire_i,
  input  logic                  busy_i,
  input  burst_kind_e           kind_i,
  input  logic [LEN_CODE_W-1:0] code_i,
  output logic                  last_o
);

  localparam int NUM_LENS = 1 << LEN_CODE_W;

  logic [CNT_W-1:0] len_m1 [NUM_LENS];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_m1;

  for (genvar g = 0; g < NUM_LENS; g++) begin : g_len
    assign len_m1[g] = CNT_W'((1 << win_log2(g, MIN_LEN_LOG2)) - 1);
  end

  assign cur_m1 = len_m1[code_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (accept_i) begin
      cnt_q <= '0;
    end else if (fire_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = busy_i && (kind_i == BK_WRAP) && (cnt_q == cur_m1);

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (busy_i && kind_i == BK_WRAP) |-> (cnt_q <= cur_m1)); // R8
  AST_LAST_ONLY_WRAP: assert property (@(posedge clk) disable iff (!rst_n) last_o |-> (kind_i == BK_WRAP)); // R6
  AST_FIRST_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n) accept_i |=> !last_o); // R8

endmodule

// File: rtl/wba_addr_core.sv
module wba_addr_core
  import wba_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int LEN_CODE_W   = 2,
  parameter int MIN_LEN_LOG2 = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept_i,
  input  logic [ADDR_W-1:0]     start_addr_i,
  input  logic                  fire_i,
  input  logic                  busy_i,
  input  burst_kind_e           kind_i,
  input  logic [LEN_CODE_W-1:0] code_i,
  output logic [ADDR_W-1:0]     addr_o
);

  localparam int NUM_LENS = 1 << LEN_CODE_W;

  logic [ADDR_W-1:0] win_mask [NUM_LENS];
  logic [ADDR_W-1:0] cur_mask;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] next_addr;

  // Low bits advance modulo the window; high bits stay
  function automatic logic [ADDR_W-1:0] wrap_step(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] m);
    logic [ADDR_W-1:0] inc;
    inc = a + 1'b1;
    return (a & ~m) | (inc & m);
  endfunction

  // Plain increment, rolls over at the top of the address space
  function automatic logic [ADDR_W-1:0] lin_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  for (genvar g = 0; g < NUM_LENS; g++) begin : g_mask
    assign win_mask[g] = ADDR_W'((64'd1 << win_log2(g, MIN_LEN_LOG2)) - 64'd1);
  end

  assign cur_mask  = win_mask[code_i];
  assign next_addr = (kind_i == BK_WRAP) ? wrap_step(addr_q, cur_mask) : lin_step(addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept_i) begin
      addr_q <= start_addr_i;
    end else if (fire_i) begin
      addr_q <= next_addr;
    end
  end

  assign addr_o = addr_q;

  AST_LOAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n) accept_i |=> (addr_o == $past(start_addr_i))); // R3
  AST_HOLD_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n) (busy_i && !fire_i) |=> $stable(addr_o)); // R4
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (fire_i && kind_i == BK_LINEAR) |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1))); // R5
  AST_WRAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (fire_i && kind_i == BK_WRAP) |=> ((addr_o & ~cur_mask) == ($past(addr_o) & ~cur_mask))); // R7

endmodule

// File: rtl/wrap_burst_agen.sv
module wrap_burst_agen
  import wba_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int LEN_CODE_W   = 2,
  parameter int MIN_LEN_LOG2 = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     start_addr_i,
  input  logic                  wrap_mode_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  stop_i,
  output logic                  idle_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic                  addr_valid_o,
  input  logic                  addr_ready_i,
  output logic                  last_o
);

  localparam int CNT_W = MIN_LEN_LOG2 + (1 << LEN_CODE_W) - 1;

  logic                  accept;
  logic                  busy;
  logic                  fire;
  logic                  last_beat;
  burst_kind_e           kind;
  logic [LEN_CODE_W-1:0] code;

  assign fire = busy && addr_ready_i;

  wba_req_ctrl #(
    .LEN_CODE_W (LEN_CODE_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .wrap_mode_i (wrap_mode_i),
    .len_code_i  (len_code_i),
    .stop_i      (stop_i),
    .fire_i      (fire),
    .last_i      (last_beat),
    .accept_o    (accept),
    .busy_o      (busy),
    .kind_o      (kind),
    .code_o      (code)
  );

  wba_beat_cnt #(
    .LEN_CODE_W   (LEN_CODE_W),
    .MIN_LEN_LOG2 (MIN_LEN_LOG2),
    .CNT_W        (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .fire_i   (fire),
    .busy_i   (busy),
    .kind_i   (kind),
    .code_i   (code),
    .last_o   (last_beat)
  );

  wba_addr_core #(
    .ADDR_W       (ADDR_W),
    .LEN_CODE_W   (LEN_CODE_W),
    .MIN_LEN_LOG2 (MIN_LEN_LOG2)
  ) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept),
    .start_addr_i (start_addr_i),
    .fire_i       (fire),
    .busy_i       (busy),
    .kind_i       (kind),
    .code_i       (code),
    .addr_o       (addr_o)
  );

  assign idle_o       = !busy;
  assign addr_valid_o = busy;
  assign last_o       = last_beat;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (idle_o && !addr_valid_o && !last_o)); // R1
  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) (addr_valid_o && addr_ready_i && last_o) |=> (!addr_valid_o && idle_o)); // R8
  AST_VALID_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (idle_o && start_i) |=> addr_valid_o); // R3

endmodule

// File: tb/wrap_burst_agen_tb_top.sv
module wrap_burst_agen_tb_top;

  typedef struct packed {
    logic        wrap;
    logic [1:0]  code;
    logic [23:0] addr;
    logic [7:0]  pat;
    logic [7:0]  nb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 24'h000105, 8'hFF,       8'd0},
    '{1'b1, 2'd1, 24'h12345F, 8'b10110110, 8'd0},
    '{1'b1, 2'd2, 24'hABCDE0, 8'hFF,       8'd0},
    '{1'b1, 2'd3, 24'h7FFFEA, 8'b11011101, 8'd0},
    '{1'b0, 2'd0, 24'hFFFFFD, 8'hFF,       8'd6},
    '{1'b0, 2'd3, 24'h000FF8, 8'b01010111, 8'd10},
    '{1'b1, 2'd3, 24'hFFFFFF, 8'hFF,       8'd0},
    '{1'b0, 2'd1, 24'h000000, 8'b10000001, 8'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] start_addr_i = '0;
  logic        wrap_mode_i = 1'b0;
  logic [1:0]  len_code_i = '0;
  logic        stop_i = 1'b0;
  logic        addr_ready_i = 1'b0;
  logic        idle_o;
  logic [23:0] addr_o;
  logic        addr_valid_o;
  logic        last_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  wrap_burst_agen dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .wrap_mode_i  (wrap_mode_i),
    .len_code_i   (len_code_i),
    .stop_i       (stop_i),
    .idle_o       (idle_o),
    .addr_o       (addr_o),
    .addr_valid_o (addr_valid_o),
    .addr_ready_i (addr_ready_i),
    .last_o       (last_o)
  );

  function automatic logic [23:0] exp_addr(input bit w, input int code,
                                           input int unsigned s, input int i);
    int unsigned len, off, r;
    len = 8 << code;
    if (w) begin
      off = s % len;
      r = s - off + ((off + i) % len);
    end else begin
      r = (s + i) & 32'h00FF_FFFF;
    end
    return r[23:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int unsigned act,
                     input int unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_quiet(input string req);
    chk(idle_o == 1'b1, req, idle_o, 1);
    chk(addr_valid_o == 1'b0, req, addr_valid_o, 0);
    chk(last_o == 1'b0, req, last_o, 0);
  endtask

  // One burst: spurious start (R2), flipped mode/code (R10) and stop in wrap (R9)
  task automatic run_burst(input vec_t v);
    int i;
    int c;
    int len;
    len = 8 << v.code;
    @(negedge clk);
    start_i = 1'b1; start_addr_i = v.addr; wrap_mode_i = v.wrap;
    len_code_i = v.code; stop_i = 1'b0; addr_ready_i = 1'b0;
    i = 0; c = 0;
    forever begin
      @(negedge clk);
      chk(addr_valid_o == 1'b1, "R3", addr_valid_o, 1);
      chk(addr_o == exp_addr(v.wrap, v.code, v.addr, i),
          v.wrap ? "R7" : "R5", addr_o, exp_addr(v.wrap, v.code, v.addr, i));
      if (v.wrap) chk(last_o == (i == len - 1), "R8", last_o, (i == len - 1));
      else        chk(last_o == 1'b0, "R6", last_o, 0);
      start_addr_i = v.addr ^ 24'h5A5A5A;
      wrap_mode_i = ~v.wrap;
      len_code_i = ~v.code;
      if (!v.wrap && i == int'(v.nb)) begin
        start_i = 1'b0; stop_i = 1'b1; addr_ready_i = 1'b0;
        break;
      end
      start_i = 1'b1;
      stop_i = v.wrap;
      addr_ready_i = v.pat[c % 8];
      if (v.wrap && addr_ready_i && i == len - 1) start_i = 1'b0;
      c++;
      if (addr_ready_i) i++;
      if (v.wrap && i == len) break;
    end
    @(negedge clk);
    check_quiet(v.wrap ? "R8" : "R6");
    start_i = 1'b0; stop_i = 1'b0; addr_ready_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1");

    for (int k = 0; k < NV; k++) run_burst(VECS[k]);

    // R4: valid held with ready low for several cycles
    @(negedge clk);
    start_i = 1'b1; start_addr_i = 24'h00003C; wrap_mode_i = 1'b1; len_code_i = 2'd0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(addr_o == 24'h00003C && addr_valid_o, "R4", addr_o, 24'h3C);
    addr_ready_i = 1'b1;
    @(negedge clk);
    addr_ready_i = 1'b0;
    chk(addr_o == 24'h00003D, "R7", addr_o, 24'h3D);
    @(negedge clk);
    chk(addr_o == 24'h00003D, "R4", addr_o, 24'h3D);

    // R1: reset in the middle of a burst
    rst_n = 1'b0;
    @(negedge clk);
    check_quiet("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule